// File: doc/BRIEF.md
# Power-Up Reset Timeout Sequencer

This block keeps a processor core in reset after a reset event until the supply and the clock can be trusted. It runs from a system clock and walks through a chain of timed stages. Each stage waits a set number of reference ticks, or a set number of oscillator edges. A power-on or brown-out event starts the full chain: a short power-on delay, an optional power-up timer, an oscillator start-up count when a crystal mode is selected, and a PLL lock delay when a PLL mode is selected. The PLL lock delay uses the same tick timer as the power-up stage.

An external reset that arrives while power is stable skips the two power stages. It goes straight to oscillator start-up, or to the stages after it. Any reset event that arrives during a sequence sends the block back to idle, and the sequence starts again once the event goes away. The stage in progress is shown on a 3-bit code. The core reset output drops only when the chain has finished.

Top module: `pwrup_seq`

## Requirements
- R1: After `rst_ni` is released, `stage_o` is 0 (idle) and `core_rst_o` is 1. Both stay that way until `por_i`, `bor_i` or `ext_rst_i` is raised.
- R2: `stage_o` encodes 0 idle, 1 power-on delay, 2 power-up timer, 3 oscillator start-up, 4 PLL lock and 5 run. No other value appears. `core_rst_o` is 0 only while `stage_o` is 5, and both change on the same clock edge.
- R3: After a `por_i` or `bor_i` event has gone low, the sequence starts in stage 1. Stage 1 lasts `POR_TICKS` ticks.
- R4: When `pwrt_en_i` is 1, stage 2 follows stage 1 and lasts `PWRT_TICKS` ticks. When `pwrt_en_i` is 0, stage 2 is skipped.
- R5: An external reset from the run stage does not enter stage 1 or stage 2. It goes to stage 3 if a crystal mode is selected, else to stage 4 if a PLL mode is selected, else straight to run.
- R6: When `xtal_mode_i` is 1, stage 3 holds until `OST_EDGES` rising edges of `osc_i` have been seen inside it. When `xtal_mode_i` is 0, stage 3 is skipped.
- R7: When `pll_mode_i` is 1, stage 4 lasts `PLL_TICKS` ticks and is the last stage before run. When `pll_mode_i` is 0, stage 4 is never entered.
- R8: Stages 1, 2 and 4 advance only on cycles where `tick_i` is 1. With `tick_i` held at 0, the stage does not change.
- R9: While any reset event input is 1, `stage_o` is 0 from the next cycle on. Once the inputs fall, the sequence restarts. If the interrupted sequence began with a power event, the restart begins at stage 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick enable, one cycle wide |
| osc_i | input | 1 | Oscillator clock, sampled and edge-counted |
| por_i | input | 1 | Power-on reset event |
| bor_i | input | 1 | Brown-out reset event |
| ext_rst_i | input | 1 | External reset event |
| pwrt_en_i | input | 1 | Enable for the power-up timer stage |
| xtal_mode_i | input | 1 | Crystal oscillator mode selected |
| pll_mode_i | input | 1 | PLL oscillator mode selected |
| core_rst_o | output | 1 | Reset to the core, active high |
| stage_o | output | 3 | Code of the current stage |

## Verification
The assertions assume that `pwrt_en_i`, `xtal_mode_i` and `pll_mode_i` are configuration inputs. They must hold steady from the cycle before an event until run is reached. The stage-skipping properties compare the current mode against the previous cycle's stage. `osc_i` is assumed to be much slower than `clk_i`, so the synchronizer never misses an edge. The bench changes modes only while the block is in run, before it pulses the next event. It toggles `osc_i` every two system cycles.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_POR  = 3'd1,
    ST_PWRT = 3'd2,
    ST_OST  = 3'd3,
    ST_PLL  = 3'd4,
    ST_RUN  = 3'd5
  } stage_e;
endpackage

// File: rtl/pwrup_tick_timer.sv
module pwrup_tick_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr_i)           cnt_q <= '0;
    else if (en_i && tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && tick_i && (({1'b0, cnt_q} + 1'b1) == {1'b0, limit_i});
endmodule

// File: rtl/pwrup_osc_count.sv
module pwrup_osc_count #(
  parameter int EDGES = 1024,
  localparam int W = $clog2(EDGES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  logic [2:0]   sync_q;
  logic [W-1:0] cnt_q;
  logic         rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], osc_i};
  end

  assign rise = sync_q[1] && !sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (clr_i)         cnt_q <= '0;
    else if (en_i && rise)  cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && rise && (({1'b0, cnt_q} + 1'b1) == (W+1)'(EDGES));
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_seq_pkg::*;
#(
  parameter int POR_TICKS  = 2,
  parameter int PWRT_TICKS = 72,
  parameter int PLL_TICKS  = 2,
  parameter int OST_EDGES  = 1024
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       osc_i,
  input  logic       por_i,
  input  logic       bor_i,
  input  logic       ext_rst_i,
  input  logic       pwrt_en_i,
  input  logic       xtal_mode_i,
  input  logic       pll_mode_i,
  output logic       core_rst_o,
  output logic [2:0] stage_o
);
  localparam int MAX_A = (POR_TICKS > PWRT_TICKS) ? POR_TICKS : PWRT_TICKS;
  localparam int MAX_T = (MAX_A > PLL_TICKS) ? MAX_A : PLL_TICKS;
  localparam int TW    = $clog2(MAX_T + 1);

  stage_e        st_q, st_d;
  logic          pend_q, pwr_q, rst_q;
  logic          evt, pwr_evt, tick_stage, tick_done, osc_done, chg;
  logic [TW-1:0] limit;
  stage_e        after_ost, after_pwrt;

  assign evt     = por_i || bor_i || ext_rst_i;
  assign pwr_evt = por_i || bor_i;

  assign after_ost  = pll_mode_i  ? ST_PLL : ST_RUN;
  assign after_pwrt = xtal_mode_i ? ST_OST : after_ost;

  always_comb begin
    st_d = st_q;
    if (evt) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (pend_q) st_d = pwr_q ? ST_POR : after_pwrt;
        ST_POR:  if (tick_done) st_d = pwrt_en_i ? ST_PWRT : after_pwrt;
        ST_PWRT: if (tick_done) st_d = after_pwrt;
        ST_OST:  if (osc_done)  st_d = after_ost;
        ST_PLL:  if (tick_done) st_d = ST_RUN;
        default: st_d = st_q;
      endcase
    end
  end

  // a power event stays pending until run is reached
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      pwr_q  <= 1'b0;
      rst_q  <= 1'b1;
    end else begin
      st_q  <= st_d;
      rst_q <= (st_d != ST_RUN);
      if (evt)                 pend_q <= 1'b1;
      else if (st_q == ST_IDLE) pend_q <= 1'b0;
      if (pwr_evt)             pwr_q <= 1'b1;
      else if (st_q == ST_RUN) pwr_q <= 1'b0;
    end
  end

  assign chg        = (st_d != st_q);
  assign tick_stage = (st_q == ST_POR) || (st_q == ST_PWRT) || (st_q == ST_PLL);

  always_comb begin
    unique case (st_q)
      ST_POR:  limit = TW'(POR_TICKS);
      ST_PWRT: limit = TW'(PWRT_TICKS);
      default: limit = TW'(PLL_TICKS);
    endcase
  end

  pwrup_tick_timer #(.W(TW)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (chg),
    .en_i    (tick_stage),
    .tick_i  (tick_i),
    .limit_i (limit),
    .done_o  (tick_done)
  );

  pwrup_osc_count #(.EDGES(OST_EDGES)) u_ost (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .osc_i  (osc_i),
    .clr_i  (chg),
    .en_i   (st_q == ST_OST),
    .done_o (osc_done)
  );

  assign stage_o    = st_q;
  assign core_rst_o = rst_q;
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       por_i,
  input logic       bor_i,
  input logic       ext_rst_i,
  input logic       pll_mode_i,
  input logic       core_rst_o,
  input logic [2:0] stage_o
);
  logic evt;
  assign evt = por_i || bor_i || ext_rst_i;

  AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_o <= 3'd5); // R2

  AST_RST_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o == (stage_o != 3'd5)); // R2

  AST_EVT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> stage_o == 3'd0); // R9

  AST_PWRT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stage_o != 3'd1 && stage_o != 3'd2) |=> stage_o != 3'd2); // R4

  AST_PLL_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pll_mode_i && stage_o != 3'd4) |=> stage_o != 3'd4); // R7

  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !evt && (stage_o == 3'd1 || stage_o == 3'd2 || stage_o == 3'd4))
      |=> $stable(stage_o)); // R8
endmodule

bind pwrup_seq pwrup_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .por_i      (por_i),
  .bor_i      (bor_i),
  .ext_rst_i  (ext_rst_i),
  .pll_mode_i (pll_mode_i),
  .core_rst_o (core_rst_o),
  .stage_o    (stage_o)
);

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;
  localparam int POR_T  = 5;
  localparam int PWRT_T = 20;
  localparam int PLL_T  = 6;
  localparam int OST_E  = 8;

  logic clk = 1'b0, rst_ni = 1'b0, tick_i = 1'b1, osc_i = 1'b0;
  logic por_i = 1'b0, bor_i = 1'b0, ext_rst_i = 1'b0;
  logic pwrt_en_i = 1'b1, xtal_mode_i = 1'b1, pll_mode_i = 1'b0;
  logic       core_rst_o;
  logic [2:0] stage_o;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  initial forever begin
    repeat (2) @(posedge clk);
    #1 osc_i = ~osc_i;
  end

  pwrup_seq #(.POR_TICKS(POR_T), .PWRT_TICKS(PWRT_T), .PLL_TICKS(PLL_T),
              .OST_EDGES(OST_E)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .osc_i(osc_i),
    .por_i(por_i), .bor_i(bor_i), .ext_rst_i(ext_rst_i),
    .pwrt_en_i(pwrt_en_i), .xtal_mode_i(xtal_mode_i), .pll_mode_i(pll_mode_i),
    .core_rst_o(core_rst_o), .stage_o(stage_o));

  // {src(0 por,1 bor,2 ext), pwrt_en, xtal, pll}
  localparam logic [4:0] VEC [8] = '{
    {2'd0, 1'b1, 1'b1, 1'b1}, {2'd2, 1'b1, 1'b1, 1'b1},
    {2'd1, 1'b0, 1'b1, 1'b0}, {2'd2, 1'b0, 1'b0, 1'b1},
    {2'd0, 1'b1, 1'b0, 1'b0}, {2'd2, 1'b1, 1'b0, 1'b0},
    {2'd1, 1'b1, 1'b1, 1'b0}, {2'd2, 1'b1, 1'b1, 1'b0}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    if (src == 0) por_i = 1'b1; else if (src == 1) bor_i = 1'b1; else ext_rst_i = 1'b1;
    @(negedge clk);
    por_i = 1'b0; bor_i = 1'b0; ext_rst_i = 1'b0;
  endtask

  task automatic wait_stage(input int s);
    for (int k = 0; k < 2000 && stage_o != 3'(s); k++) @(negedge clk);
  endtask

  task automatic walk(input int src, input bit pw, input bit xt, input bit pl);
    int exp_s[4];
    int n = 0;
    pwrt_en_i = pw; xtal_mode_i = xt; pll_mode_i = pl;
    if (src != 2) exp_s[n++] = 1;
    if (src != 2 && pw) exp_s[n++] = 2;
    if (xt) exp_s[n++] = 3;
    if (pl) exp_s[n++] = 4;
    pulse(src);
    chk(stage_o == 3'd0, "R9", stage_o, 0);
    for (int k = 0; k < 10 && stage_o == 3'd0; k++) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int dur = 0;
      string tag;
      tag = (src == 2) ? "R5" : (exp_s[i] == 1) ? "R3" : (exp_s[i] == 2) ? "R4" :
            (exp_s[i] == 3) ? "R6" : "R7";
      chk(stage_o == 3'(exp_s[i]), tag, stage_o, exp_s[i]);
      chk(core_rst_o == 1'b1, "R2", core_rst_o, 1);
      while (stage_o == 3'(exp_s[i]) && dur < 1000) begin dur++; @(negedge clk); end
      case (exp_s[i])
        1: chk(dur == POR_T, "R3", dur, POR_T);
        2: chk(dur == PWRT_T, "R4", dur, PWRT_T);
        3: chk(dur >= 4*OST_E-6 && dur <= 4*OST_E+6, "R6", dur, 4*OST_E);
        default: chk(dur == PLL_T, "R7", dur, PLL_T);
      endcase
    end
    chk(stage_o == 3'd5, (src == 2) ? "R5" : "R2", stage_o, 5);
    chk(core_rst_o == 1'b0, "R2", core_rst_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(stage_o == 3'd0, "R1", stage_o, 0);
    chk(core_rst_o == 1'b1, "R1", core_rst_o, 1);
    repeat (20) @(negedge clk);
    chk(stage_o == 3'd0, "R1", stage_o, 0);

    foreach (VEC[i]) walk(int'(VEC[i][4:3]), VEC[i][2], VEC[i][1], VEC[i][0]);

    // R8: no tick, no progress in the power-up stage
    pwrt_en_i = 1'b1; xtal_mode_i = 1'b0; pll_mode_i = 1'b0;
    pulse(0);
    wait_stage(2);
    tick_i = 1'b0;
    repeat (30) @(negedge clk);
    chk(stage_o == 3'd2, "R8", stage_o, 2);
    tick_i = 1'b1;
    wait_stage(5);
    chk(stage_o == 3'd5, "R8", stage_o, 5);

    // R9: external reset during power sequence restarts at stage 1
    pulse(1);
    wait_stage(2);
    pulse(2);
    chk(stage_o == 3'd0, "R9", stage_o, 0);
    @(negedge clk);
    chk(stage_o == 3'd1, "R9", stage_o, 1);
    wait_stage(5);

    // R9: held event keeps idle
    @(negedge clk);
    ext_rst_i = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      chk(stage_o == 3'd0 && core_rst_o, "R9", stage_o, 0);
      @(negedge clk);
    end
    ext_rst_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(stage_o == 3'd5, "R5", stage_o, 5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", stage_o, 5);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule